// File: doc/BRIEF.md
# Express-Bypass Output Switch Allocator

This block owns one output port of a network-on-chip router whose links carry both ordinary virtual channels and express virtual channels. Flits of ordinary channels wait in their input buffers and raise a request when they are ready for switch allocation. A head flit comes to this stage only after its routing and channel allocation, and body or tail flits come directly. Ordinary requesters are arbitrated round-robin. A requester that loses keeps its flit in its buffer and requests again in a later cycle.

An express flit that passes through this router as a bypass node does not arbitrate and is never buffered here. At most one express channel can reach a given output, so one cycle before the express flit arrives, a one-bit lookahead reserves the output for it. In the reserved cycle the crossbar selects the express input, no ordinary grant is issued, and the express flit goes straight into the traversal register. The traversal stage registers the selected flit, its head flag, an express marker and a valid bit.

Top module: `xbyp_out_alloc`

## Requirements
- R1: In the cycle after a synchronous active-low reset, `out_vld` is 0 and `gnt` is 0 while there are no requests. The round-robin priority starts at requester 0.
- R2: `gnt` has at most one bit set, and only on a requester whose `req` bit is high.
- R3: Ordinary requesters are served round-robin. After requester i is granted, priority starts at requester (i+1) mod N_IN. When nothing is reserved and at least one request is high, a grant is always issued.
- R4: If `exp_la` is high in cycle t, then in cycle t+1 `gnt` is 0 and `xbar_sel` equals N_IN, whatever the requests are.
- R5: In a reserved cycle t+1, the values on `exp_flit` and `exp_head` appear on `out_flit` and `out_head` in cycle t+2, with `out_vld`=1 and `out_exp`=1.
- R6: If requester w is granted in cycle t, then `xbar_sel` equals w in cycle t. In cycle t+1, `out_flit` equals slice w of `req_flit` (bits w*FLIT_W upward), `out_head` equals `req_head[w]`, `out_vld`=1 and `out_exp`=0.
- R7: A reserved cycle leaves the round-robin priority unchanged, so every requester that was waiting keeps its place in the order.
- R8: A cycle with no reservation and no request gives `out_vld`=0 and `out_exp`=0 in the next cycle, and `xbar_sel` reads 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_IN | Ordinary requester wants the output this cycle |
| req_head | input | N_IN | Head flag of each requester's flit |
| req_flit | input | N_IN*FLIT_W | Flits of all requesters, requester i in bits i*FLIT_W upward |
| exp_la | input | 1 | Lookahead: an express flit arrives in the next cycle |
| exp_flit | input | FLIT_W | Express flit, valid in the cycle after the lookahead |
| exp_head | input | 1 | Head flag of the express flit |
| gnt | output | N_IN | One-hot grant to ordinary requesters |
| xbar_sel | output | $clog2(N_IN+1) | Crossbar select: winner index, N_IN for express, 0 when idle |
| out_vld | output | 1 | Registered output flit is valid |
| out_exp | output | 1 | Registered output flit came from the express channel |
| out_head | output | 1 | Head flag of the registered output flit |
| out_flit | output | FLIT_W | Registered output flit |

## Verification
The bench drives all requesters continuously, which shows that the rotation visits every input in order and wraps. It then drives sparse and changing request sets, which shows that the arbiter skips idle inputs correctly. Lookaheads are inserted while every input requests, including two back to back. These cases separate an arbiter that lets an ordinary grant through in a reserved cycle, or that moves its pointer there, from a correct one. A lookahead raised in the same cycle as an ordinary grant confirms that the reservation applies only to the following cycle. Idle cycles between bursts confirm that the valid bit drops and that the select returns to 0.

// File: rtl/xbyp_pkg.sv
// Shared helpers for the express-bypass output allocator.
// Assumes requester counts of at least two.
package xbyp_pkg;
    // Next index in a circular order of n entries.
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/xbyp_la_ctl.sv
// Lookahead reservation: turns the one-bit express announcement of
// cycle t into a reservation of the output in cycle t+1.
// Assumes at most one express channel can target this output.
module xbyp_la_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic exp_la,
    output logic res_q
);
    // Register the lookahead; reset clears any pending reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= 1'b0;
        else        res_q <= exp_la;
    end
endmodule

// File: rtl/xbyp_rr_arb.sv
// Round-robin arbiter for ordinary requesters. The priority pointer
// advances past the winner only when a grant is issued; while disabled
// no grant is issued and the pointer holds.
// Assumes N_IN >= 2.
module xbyp_rr_arb
    import xbyp_pkg::*;
#(
    parameter int N_IN = 4,
    localparam int IW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [N_IN-1:0] req,
    output logic [N_IN-1:0] gnt,
    output logic [IW-1:0]   win,
    output logic            any
);
    logic [IW-1:0] ptr;

    // Search the requesters starting from the pointer and take the first.
    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int k = 0; k < N_IN; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N_IN) c = c - N_IN;
            if (en && !any && req[c]) begin
                any    = 1'b1;
                gnt[c] = 1'b1;
                win    = IW'(c);
            end
        end
    end

    // Move the priority pointer past the winner of an issued grant.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (any) ptr <= IW'(rr_next(int'(win), N_IN));
    end

    // R7: the pointer is frozen in a cycle without a grant
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !any) |-> $stable(ptr));
    // R3: an issued grant moves the pointer to the slot after the winner
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && any) |-> (ptr != $past(win)));
endmodule

// File: rtl/xbyp_st_stage.sv
// Switch traversal register: captures the express flit in a reserved
// cycle, otherwise the winning ordinary flit, and raises valid only when
// one of the two is present.
// Assumes a reservation and an ordinary grant never coincide.
module xbyp_st_stage #(
    parameter int N_IN   = 4,
    parameter int FLIT_W = 32,
    localparam int IW = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   res,
    input  logic                   any,
    input  logic [IW-1:0]          win,
    input  logic [N_IN*FLIT_W-1:0] req_flit,
    input  logic [N_IN-1:0]        req_head,
    input  logic [FLIT_W-1:0]      exp_flit,
    input  logic                   exp_head,
    output logic                   out_vld,
    output logic                   out_exp,
    output logic                   out_head,
    output logic [FLIT_W-1:0]      out_flit
);
    logic [FLIT_W-1:0] nrm_flit;

    // Crossbar column for the ordinary winner.
    assign nrm_flit = req_flit[int'(win)*FLIT_W +: FLIT_W];

    // Register the selected flit together with its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_exp  <= 1'b0;
            out_head <= 1'b0;
            out_flit <= '0;
        end else if (res) begin
            out_vld  <= 1'b1;
            out_exp  <= 1'b1;
            out_head <= exp_head;
            out_flit <= exp_flit;
        end else if (any) begin
            out_vld  <= 1'b1;
            out_exp  <= 1'b0;
            out_head <= req_head[win];
            out_flit <= nrm_flit;
        end else begin
            out_vld  <= 1'b0;
            out_exp  <= 1'b0;
            out_head <= 1'b0;
        end
    end

    // R5: a reserved cycle yields a valid express flit one cycle later
    a_r5_exp_out: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && res) |-> (out_vld && out_exp));
    // R8: nothing selected yields no valid output
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !res && !any) |-> (!out_vld && !out_exp));
endmodule

// File: rtl/xbyp_out_alloc.sv
// Output-port switch allocator and traversal for a router with express
// bypass. Ordinary requesters arbitrate round-robin; a one-bit lookahead
// reserves the following cycle for an express flit, which skips
// arbitration and goes straight to the traversal register.
// Assumes head flits request only after routing and channel allocation.
module xbyp_out_alloc #(
    parameter int N_IN   = 4,
    parameter int FLIT_W = 32,
    localparam int IW = $clog2(N_IN),
    localparam int SW = $clog2(N_IN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        req,
    input  logic [N_IN-1:0]        req_head,
    input  logic [N_IN*FLIT_W-1:0] req_flit,
    input  logic                   exp_la,
    input  logic [FLIT_W-1:0]      exp_flit,
    input  logic                   exp_head,
    output logic [N_IN-1:0]        gnt,
    output logic [SW-1:0]          xbar_sel,
    output logic                   out_vld,
    output logic                   out_exp,
    output logic                   out_head,
    output logic [FLIT_W-1:0]      out_flit
);
    logic          res_q;
    logic          any;
    logic [IW-1:0] win;

    xbyp_la_ctl u_la (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_la (exp_la),
        .res_q  (res_q)
    );

    xbyp_rr_arb #(.N_IN(N_IN)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!res_q),
        .req   (req),
        .gnt   (gnt),
        .win   (win),
        .any   (any)
    );

    xbyp_st_stage #(.N_IN(N_IN), .FLIT_W(FLIT_W)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .res      (res_q),
        .any      (any),
        .win      (win),
        .req_flit (req_flit),
        .req_head (req_head),
        .exp_flit (exp_flit),
        .exp_head (exp_head),
        .out_vld  (out_vld),
        .out_exp  (out_exp),
        .out_head (out_head),
        .out_flit (out_flit)
    );

    // Crossbar select: express column, ordinary winner, or idle zero.
    always_comb begin
        if (res_q)    xbar_sel = SW'(N_IN);
        else if (any) xbar_sel = SW'(win);
        else          xbar_sel = '0;
    end

    // R2: at most one grant, and only to a requester
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));
    // R4: a lookahead blocks every ordinary grant in the next cycle
    a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && exp_la) |-> (gnt == '0 && xbar_sel == SW'(N_IN)));
    // R3: without a reservation, some request always wins
    a_r3_work_cons: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n && exp_la) && req != '0) |-> (gnt != '0));
endmodule

// File: tb/sim_xbyp_out_alloc.sv
module sim_xbyp_out_alloc;
    localparam int CLK_P = 10;
    localparam int N  = 4;
    localparam int W  = 32;
    localparam int SW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    req_head = '0;
    logic [N*W-1:0]  req_flit = '0;
    logic            exp_la = 1'b0;
    logic [W-1:0]    exp_flit = '0;
    logic            exp_head = 1'b0;
    logic [N-1:0]    gnt;
    logic [SW-1:0]   xbar_sel;
    logic            out_vld, out_exp, out_head;
    logic [W-1:0]    out_flit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mptr = 0;
    bit mres = 1'b0;

    typedef struct {
        bit         v;
        bit         e;
        bit         h;
        bit [W-1:0] f;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    xbyp_out_alloc #(.N_IN(N), .FLIT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_head(req_head),
        .req_flit(req_flit), .exp_la(exp_la), .exp_flit(exp_flit),
        .exp_head(exp_head), .gnt(gnt), .xbar_sel(xbar_sel),
        .out_vld(out_vld), .out_exp(out_exp), .out_head(out_head),
        .out_flit(out_flit)
    );

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus, check the allocation outputs,
    // and queue the traversal result expected one cycle later.
    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] hd,
                         input bit la, input string tag);
        item_t it;
        logic [N-1:0] eg;
        int w;
        @(negedge clk);
        req = r;
        req_head = hd;
        exp_la = la;
        for (int i = 0; i < N; i++)
            req_flit[i*W +: W] = 32'hA000_0000 | (i << 16) | (cyc & 16'hFFFF);
        exp_flit = 32'hE000_0000 | (cyc & 16'hFFFF);
        exp_head = cyc[0];
        eg = '0;
        w = -1;
        if (!mres) begin
            for (int k = 0; k < N; k++) begin
                int c;
                c = (mptr + k) % N;
                if (w < 0 && r[c]) w = c;
            end
            if (w >= 0) eg[w] = 1'b1;
        end
        #1;
        chk({tag, " gnt"}, gnt, eg);
        chk({tag, " sel"}, xbar_sel, mres ? N : (w >= 0 ? w : 0));
        it.tag = tag;
        if (mres) begin
            it.v = 1; it.e = 1; it.h = exp_head; it.f = exp_flit;
        end else if (w >= 0) begin
            it.v = 1; it.e = 0; it.h = hd[w]; it.f = req_flit[w*W +: W];
            mptr = (w + 1) % N;
        end else begin
            it.v = 0; it.e = 0; it.h = 0; it.f = '0;
        end
        sb.push_back(it);
        mres = la;
        cyc++;
    endtask

    // Monitor: compare registered outputs after each edge against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk({it.tag, " out_vld"}, out_vld, it.v);
                chk({it.tag, " out_exp"}, out_exp, it.e);
                if (it.v) begin
                    chk({it.tag, " out_head"}, out_head, it.h);
                    chk({it.tag, " out_flit"}, out_flit, it.f);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 out_vld after reset", out_vld, 0);
        chk("R1 gnt after reset", gnt, 0);
        // R1/R3: all requesting, rotation from requester 0 with wrap
        drive(4'b1111, 4'b0001, 0, "R1");
        drive(4'b1111, 4'b0010, 0, "R3");
        drive(4'b1111, 4'b0100, 0, "R3");
        drive(4'b1111, 4'b1000, 0, "R3");
        drive(4'b1111, 4'b1111, 0, "R3");
        // R6/R2: sparse requests skip idle inputs
        drive(4'b1010, 4'b1000, 0, "R6");
        drive(4'b1010, 4'b0010, 0, "R6");
        drive(4'b0100, 4'b0000, 0, "R2");
        // R8: idle cycle
        drive(4'b0000, 4'b0000, 0, "R8");
        // R4/R5/R7: lookahead raised while a grant is issued this cycle
        drive(4'b1111, 4'b0000, 1, "R6");
        drive(4'b1111, 4'b0000, 0, "R4");
        drive(4'b1111, 4'b0000, 0, "R7");
        // R4/R5: back-to-back lookaheads
        drive(4'b1111, 4'b0001, 1, "R3");
        drive(4'b1111, 4'b0001, 1, "R5");
        drive(4'b1111, 4'b0001, 0, "R4");
        drive(4'b1111, 4'b0001, 0, "R7");
        // R4/R8: express during an otherwise idle period
        drive(4'b0000, 4'b0000, 1, "R8");
        drive(4'b0000, 4'b0000, 0, "R5");
        drive(4'b0000, 4'b0000, 0, "R8");
        drive(4'b0001, 4'b0001, 0, "R3");
        drive(4'b0000, 4'b0000, 0, "R8");
        wait (sb.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule